// File: doc/BRIEF.md
# Single-Address Coherence Home Controller

This block is the home side of a directory-based, message-passing coherence scheme for one memory address shared by `N` cache nodes. It records which nodes hold a readable copy (the sharer set), whether a writable copy is out (the exclusive flag), and the memory data word. Each node has three single-entry channels to the home: a request slot the node fills, a grant slot the home fills with invalidations and grants, and an acknowledgement slot the node fills when it gives up its copy. All command fields use one 3-bit message code: 0 none, 1 read-shared request, 2 exclusive request, 3 invalidate, 4 invalidate acknowledgement, 5 shared grant, 6 exclusive grant.

Service is serialised. A state machine with states `SRV_IDLE`, `SRV_SHARED` and `SRV_EXCL` holds the command being served. Transitions are `accept` (`SRV_IDLE` to `SRV_SHARED` or `SRV_EXCL`, taking a request, saving its sender and copying the sharer set into a pending-invalidate set) and `grant` (either busy state back to `SRV_IDLE`). While busy, the controller sends invalidations from the pending set, and it takes acknowledgements. An acknowledgement taken while the exclusive copy is out returns the modified data word to memory. Only one action happens in a cycle. A fixed priority picks it, and a rotating pointer picks the node for each kind of action.

Top module: `coh_home_ctrl`

## Requirements
- R1: After reset every grant slot holds code 0 (none), and no request or acknowledgement is taken while the inputs are idle.
- R2: A request (code 1 or 2 in a node's request slot) is taken, by a one-cycle `req_take_o` pulse for that node, only in `SRV_IDLE`. A request held while another is in service is not taken until the controller is idle again.
- R3: While an exclusive request is served, every node that was a sharer at acceptance receives exactly one invalidate (code 3) in its grant slot, once that slot is empty.
- R4: While a shared request is served, invalidates are sent only if the exclusive flag is set. With no exclusive copy out, sharers' grant slots stay at code 0.
- R5: An acknowledgement is taken (`ack_take_o` pulse) only while a request is in service, and taking it removes that node from the sharer set. An acknowledgement presented in `SRV_IDLE` is left in its slot.
- R6: An acknowledgement taken while the exclusive flag is set clears the flag and replaces memory data with the acknowledgement's data word. Any other acknowledgement leaves memory data unchanged.
- R7: A shared request is granted with code 5 and the current memory data in the requester's grant slot, as soon as no exclusive copy is out and that slot is empty. The requester joins the sharer set and the controller returns to `SRV_IDLE`.
- R8: An exclusive grant (code 6 with memory data) is issued only when the sharer set is empty, no exclusive copy is out and the requester's grant slot is empty. It sets the exclusive flag, makes the requester the only sharer, and returns to `SRV_IDLE`.
- R9: At most one action happens per cycle. The priority is acknowledgement first, then grant, then invalidate, then request acceptance.
- R10: Among nodes, each kind of action uses a rotating pointer that starts after the last winner, so a node that has just been served cannot win again over another node that is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cmd_i | input | N*3 | Request slot command of each node, node k at bits [3k+2:3k] |
| req_take_o | output | N | One-cycle pulse: the node's request slot is consumed |
| gnt_cmd_o | output | N*3 | Grant slot command of each node |
| gnt_data_o | output | N*W | Grant slot data word of each node |
| gnt_take_i | input | N | Node has read its grant slot; the slot empties at the edge |
| ack_valid_i | input | N | Acknowledgement slot of the node is full |
| ack_data_i | input | N*W | Data word carried by each acknowledgement |
| ack_take_o | output | N | One-cycle pulse: the node's acknowledgement is consumed |

## Verification
The take pulses are combinational, so the bench reads them about a nanosecond after it drives a slot, before the next rising edge. Grant-slot results are registered. An invalidate or grant appears one edge after the cycle that enables it, which means a grant shows two edges after the request is first driven when no invalidates are needed. The bench drives inputs on falling edges and samples on the falling edge after the edge that it has counted as the one making each change. It also checks that a slot which must stay empty is still empty one cycle after the point where it would otherwise have changed.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        MSG_NONE    = 3'd0,
        MSG_REQ_SH  = 3'd1,
        MSG_REQ_EX  = 3'd2,
        MSG_INV     = 3'd3,
        MSG_INV_ACK = 3'd4,
        MSG_GNT_SH  = 3'd5,
        MSG_GNT_EX  = 3'd6
    } msg_cmd_e;

    typedef enum logic [1:0] {
        SRV_IDLE,
        SRV_SHARED,
        SRV_EXCL
    } srv_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_ACK,
        ACT_GRANT,
        ACT_INV,
        ACT_ACCEPT
    } act_e;

endpackage

// File: rtl/coh_rr_pick.sv
module coh_rr_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  cand_i,
    input  logic          advance_i,
    output logic [N-1:0]  win_o,
    output logic [IW-1:0] win_idx_o
);

    logic [IW-1:0] ptr_q;
    logic          found;

    always_comb begin
        win_o     = '0;
        win_idx_o = '0;
        found     = 1'b0;
        for (int k = 0; k < N; k++) begin
            int pos;
            pos = int'(ptr_q) + k;
            if (pos >= N) pos = pos - N;
            if (!found && cand_i[pos]) begin
                found       = 1'b1;
                win_o[pos]  = 1'b1;
                win_idx_o   = IW'(pos);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance_i) begin
            ptr_q <= (win_idx_o == IW'(N - 1)) ? '0 : win_idx_o + 1'b1;
        end
    end

endmodule

// File: rtl/coh_gnt_slots.sv
module coh_gnt_slots
    import coh_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   load_i,
    input  msg_cmd_e       load_cmd_i,
    input  logic [W-1:0]   load_data_i,
    input  logic [N-1:0]   take_i,
    output logic [N*3-1:0] cmd_o,
    output logic [N*W-1:0] data_o,
    output logic [N-1:0]   empty_o
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        msg_cmd_e     cmd_q;
        logic [W-1:0] data_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmd_q  <= MSG_NONE;
                data_q <= '0;
            end else if (load_i[g]) begin
                cmd_q  <= load_cmd_i;
                data_q <= load_data_i;
            end else if (take_i[g]) begin
                cmd_q  <= MSG_NONE;
                data_q <= '0;
            end
        end

        assign cmd_o[g*3 +: 3]  = cmd_q;
        assign data_o[g*W +: W] = data_q;
        assign empty_o[g]       = (cmd_q == MSG_NONE);
    end

endmodule

// File: rtl/coh_home_ctrl.sv
module coh_home_ctrl
    import coh_pkg::*;
#(
    parameter int          N        = 4,
    parameter int          W        = 8,
    parameter logic [W-1:0] MEM_INIT = 8'h5A,
    localparam int         IW       = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*3-1:0] req_cmd_i,
    output logic [N-1:0]   req_take_o,
    output logic [N*3-1:0] gnt_cmd_o,
    output logic [N*W-1:0] gnt_data_o,
    input  logic [N-1:0]   gnt_take_i,
    input  logic [N-1:0]   ack_valid_i,
    input  logic [N*W-1:0] ack_data_i,
    output logic [N-1:0]   ack_take_o
);

    srv_state_e    cur_q, cur_d;
    act_e          act;
    logic [N-1:0]  shr_q, inv_set_q;
    logic          excl_q;
    logic [IW-1:0] owner_q;
    logic [W-1:0]  mem_q;

    msg_cmd_e      req_cmd [N];
    logic [W-1:0]  ack_data [N];
    logic [N-1:0]  req_pend, ack_pend, inv_pend;
    logic [N-1:0]  req_win, ack_win, inv_win;
    logic [IW-1:0] req_idx, ack_idx, inv_idx;
    logic [N-1:0]  gnt_empty;
    logic          busy, gnt_ok, inv_allowed;
    logic [N-1:0]  slot_load;
    msg_cmd_e      slot_cmd;
    logic [W-1:0]  slot_data;

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign req_cmd[g]  = msg_cmd_e'(req_cmd_i[g*3 +: 3]);
        assign ack_data[g] = ack_data_i[g*W +: W];
        assign req_pend[g] = !busy && (req_cmd[g] == MSG_REQ_SH || req_cmd[g] == MSG_REQ_EX);
    end

    assign busy        = (cur_q != SRV_IDLE);
    assign ack_pend    = busy ? ack_valid_i : '0;
    assign inv_allowed = (cur_q == SRV_EXCL) || (cur_q == SRV_SHARED && excl_q);
    assign inv_pend    = inv_allowed ? (inv_set_q & gnt_empty) : '0;
    assign gnt_ok      = gnt_empty[owner_q] && !excl_q &&
                         ((cur_q == SRV_SHARED) || (cur_q == SRV_EXCL && shr_q == '0));

    // fixed priority among action kinds
    always_comb begin
        if (|ack_pend)       act = ACT_ACK;
        else if (gnt_ok)     act = ACT_GRANT;
        else if (|inv_pend)  act = ACT_INV;
        else if (|req_pend)  act = ACT_ACCEPT;
        else                 act = ACT_NONE;
    end

    coh_rr_pick #(.N(N)) u_ack_arb (
        .clk(clk), .rst_n(rst_n), .cand_i(ack_pend), .advance_i(act == ACT_ACK),
        .win_o(ack_win), .win_idx_o(ack_idx)
    );
    coh_rr_pick #(.N(N)) u_inv_arb (
        .clk(clk), .rst_n(rst_n), .cand_i(inv_pend), .advance_i(act == ACT_INV),
        .win_o(inv_win), .win_idx_o(inv_idx)
    );
    coh_rr_pick #(.N(N)) u_req_arb (
        .clk(clk), .rst_n(rst_n), .cand_i(req_pend), .advance_i(act == ACT_ACCEPT),
        .win_o(req_win), .win_idx_o(req_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= SRV_IDLE;
        else        cur_q <= cur_d;
    end

    // next state
    always_comb begin
        cur_d = cur_q;
        unique case (cur_q)
            SRV_IDLE: begin
                if (act == ACT_ACCEPT)
                    cur_d = (req_cmd[req_idx] == MSG_REQ_EX) ? SRV_EXCL : SRV_SHARED;
            end
            SRV_SHARED, SRV_EXCL: begin
                if (act == ACT_GRANT) cur_d = SRV_IDLE;
            end
            default: cur_d = SRV_IDLE;
        endcase
    end

    // outputs and slot loads
    always_comb begin
        req_take_o = (act == ACT_ACCEPT) ? req_win : '0;
        ack_take_o = (act == ACT_ACK)    ? ack_win : '0;
        slot_load  = '0;
        slot_cmd   = MSG_NONE;
        slot_data  = '0;
        unique case (act)
            ACT_GRANT: begin
                slot_load[owner_q] = 1'b1;
                slot_cmd  = (cur_q == SRV_EXCL) ? MSG_GNT_EX : MSG_GNT_SH;
                slot_data = mem_q;
            end
            ACT_INV: begin
                slot_load = inv_win;
                slot_cmd  = MSG_INV;
            end
            default: ;
        endcase
    end

    // directory state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shr_q     <= '0;
            inv_set_q <= '0;
            excl_q    <= 1'b0;
            owner_q   <= '0;
            mem_q     <= MEM_INIT;
        end else begin
            unique case (act)
                ACT_ACK: begin
                    shr_q[ack_idx] <= 1'b0;
                    if (excl_q) begin
                        excl_q <= 1'b0;
                        mem_q  <= ack_data[ack_idx];
                    end
                end
                ACT_GRANT: begin
                    shr_q[owner_q] <= 1'b1;
                    if (cur_q == SRV_EXCL) excl_q <= 1'b1;
                end
                ACT_INV:    inv_set_q[inv_idx] <= 1'b0;
                ACT_ACCEPT: begin
                    owner_q   <= req_idx;
                    inv_set_q <= shr_q;
                end
                default: ;
            endcase
        end
    end

    coh_gnt_slots #(.N(N), .W(W)) u_slots (
        .clk(clk), .rst_n(rst_n), .load_i(slot_load), .load_cmd_i(slot_cmd),
        .load_data_i(slot_data), .take_i(gnt_take_i), .cmd_o(gnt_cmd_o),
        .data_o(gnt_data_o), .empty_o(gnt_empty)
    );

endmodule

// File: rtl/coh_home_ctrl_chk.sv
module coh_home_ctrl_chk
    import coh_pkg::*;
#(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_take,
    input logic [N-1:0] ack_take,
    input srv_state_e   cur,
    input logic         excl,
    input logic [N-1:0] shr
);

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_take) && $onehot0(ack_take) && !(|req_take && |ack_take)); // R9

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        |req_take |-> cur == SRV_IDLE); // R2

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        |req_take |=> cur != SRV_IDLE); // R2

    AST_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        |ack_take |-> cur != SRV_IDLE); // R5

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        |ack_take |=> (shr & $past(ack_take)) == '0); // R5

    AST_EXCL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_take && excl) |=> !excl); // R6

    AST_EXCL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(excl) |-> ($countones(shr) == 1 && $past(shr) == '0)); // R8

endmodule

bind coh_home_ctrl coh_home_ctrl_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_take(req_take_o), .ack_take(ack_take_o),
    .cur(cur_q), .excl(excl_q), .shr(shr_q)
);

// File: tb/coh_home_ctrl_bench.sv
module coh_home_ctrl_bench;
    import coh_pkg::*;

    localparam int  N   = 4;
    localparam int  W   = 8;
    localparam time TCK = 10ns;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*3-1:0] req_cmd = '0;
    logic [N-1:0]   req_take;
    logic [N*3-1:0] gnt_cmd;
    logic [N*W-1:0] gnt_data;
    logic [N-1:0]   gnt_take = '0;
    logic [N-1:0]   ack_valid = '0;
    logic [N*W-1:0] ack_data = '0;
    logic [N-1:0]   ack_take;

    int total = 0;
    int bad   = 0;

    always #(TCK/2) clk = ~clk;

    coh_home_ctrl #(.N(N), .W(W), .MEM_INIT(8'h5A)) u_coh_home_ctrl (
        .clk(clk), .rst_n(rst_n), .req_cmd_i(req_cmd), .req_take_o(req_take),
        .gnt_cmd_o(gnt_cmd), .gnt_data_o(gnt_data), .gnt_take_i(gnt_take),
        .ack_valid_i(ack_valid), .ack_data_i(ack_data), .ack_take_o(ack_take)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int slot_cmd(input int k);
        return int'(gnt_cmd[k*3 +: 3]);
    endfunction

    function automatic int slot_dat(input int k);
        return int'(gnt_data[k*W +: W]);
    endfunction

    task automatic set_req(input int k, input msg_cmd_e c);
        req_cmd[k*3 +: 3] = c;
    endtask

    task automatic consume_slot(input int k);
        gnt_take[k] = 1'b1;
        tick();
        gnt_take[k] = 1'b0;
    endtask

    task automatic send_ack(input int k, input logic [W-1:0] d, input string tag);
        ack_valid[k] = 1'b1;
        ack_data[k*W +: W] = d;
        #1;
        chk(ack_take == N'(1 << k), tag, int'(ack_take), 1 << k);
        tick();
        ack_valid[k] = 1'b0;
    endtask

    task automatic t_reset();
        for (int k = 0; k < N; k++)
            chk(slot_cmd(k) == 0, "R1 slot empty", slot_cmd(k), 0);
        chk(req_take == '0 && ack_take == '0, "R1 no take", int'({req_take, ack_take}), 0);
    endtask

    task automatic t_first_shared();
        set_req(1, MSG_REQ_SH);
        #1;
        chk(req_take == 4'b0010, "R2 accept idle", int'(req_take), 2);
        tick();
        set_req(1, MSG_NONE);
        chk(slot_cmd(1) == 0, "R7 grant not early", slot_cmd(1), 0);
        tick();
        chk(slot_cmd(1) == 5 && slot_dat(1) == 8'h5A, "R7 GntS data", slot_dat(1), 8'h5A);
        consume_slot(1);
    endtask

    task automatic t_exclusive_over_sharer();
        set_req(2, MSG_REQ_EX);
        #1;
        chk(req_take == 4'b0100, "R2 accept ReqE", int'(req_take), 4);
        tick();
        set_req(2, MSG_NONE);
        tick();
        chk(slot_cmd(1) == 3, "R3 inv sharer", slot_cmd(1), 3);
        chk(slot_cmd(2) == 0, "R8 no GntE with sharer", slot_cmd(2), 0);
        tick();
        chk(slot_cmd(2) == 0, "R8 GntE still held", slot_cmd(2), 0);
        consume_slot(1);
        send_ack(1, 8'h11, "R5 ack busy");
        tick();
        chk(slot_cmd(2) == 6 && slot_dat(2) == 8'h5A, "R8 GntE after ack", slot_dat(2), 8'h5A);
        consume_slot(2);
    endtask

    task automatic t_ack_idle();
        ack_valid[0] = 1'b1;
        ack_data[0 +: W] = 8'hFF;
        #1;
        chk(ack_take == '0, "R5 idle ack left", int'(ack_take), 0);
        tick();
        chk(ack_take == '0, "R5 idle ack left 2", int'(ack_take), 0);
        ack_valid[0] = 1'b0;
    endtask

    task automatic t_shared_over_excl();
        set_req(3, MSG_REQ_SH);
        #1;
        chk(req_take == 4'b1000, "R2 accept ReqS", int'(req_take), 8);
        tick();
        set_req(3, MSG_NONE);
        tick();
        chk(slot_cmd(2) == 3, "R4 inv owner", slot_cmd(2), 3);
        consume_slot(2);
        send_ack(2, 8'hC3, "R5 ack from owner");
        tick();
        chk(slot_cmd(3) == 5 && slot_dat(3) == 8'hC3, "R6 dirty data returned", slot_dat(3), 8'hC3);
        consume_slot(3);
    endtask

    task automatic t_shared_no_inv();
        set_req(0, MSG_REQ_SH);
        #1;
        chk(req_take == 4'b0001, "R2 accept node0", int'(req_take), 1);
        tick();
        set_req(0, MSG_NONE);
        tick();
        chk(slot_cmd(0) == 5 && slot_dat(0) == 8'hC3, "R7 GntS node0", slot_dat(0), 8'hC3);
        chk(slot_cmd(3) == 0, "R4 no inv to sharer", slot_cmd(3), 0);
        consume_slot(0);
        chk(slot_cmd(3) == 0, "R4 sharer untouched", slot_cmd(3), 0);
    endtask

    task automatic t_priority();
        logic [N-1:0] first;
        set_req(1, MSG_REQ_SH);
        #1;
        chk(req_take == 4'b0010, "R2 accept node1", int'(req_take), 2);
        tick();
        set_req(1, MSG_NONE);
        ack_valid[3] = 1'b1;
        ack_data[3*W +: W] = 8'h77;
        set_req(2, MSG_REQ_EX);
        #1;
        chk(ack_take == 4'b1000, "R9 ack beats grant", int'(ack_take), 8);
        chk(req_take == '0, "R2 no accept busy", int'(req_take), 0);
        tick();
        ack_valid[3] = 1'b0;
        chk(slot_cmd(1) == 0, "R9 grant deferred", slot_cmd(1), 0);
        tick();
        chk(slot_cmd(1) == 5 && slot_dat(1) == 8'hC3, "R6 clean ack keeps mem", slot_dat(1), 8'hC3);
        gnt_take[1] = 1'b1;
        #1;
        chk(req_take == 4'b0100, "R2 held req taken", int'(req_take), 4);
        tick();
        gnt_take[1] = 1'b0;
        set_req(2, MSG_NONE);
        tick();
        tick();
        chk(slot_cmd(0) == 3 && slot_cmd(1) == 3, "R3 both sharers inv",
            int'({gnt_cmd[2:0], gnt_cmd[5:3]}), 8'h1B);
        gnt_take = 4'b0011;
        tick();
        gnt_take = '0;
        ack_valid = 4'b0011;
        #1;
        first = ack_take;
        chk($countones(first) == 1 && (first & 4'b0011) == first, "R9 one ack per cycle",
            int'(first), 1);
        tick();
        ack_valid = ack_valid & ~first;
        #1;
        chk(ack_take == ack_valid, "R5 second ack", int'(ack_take), int'(ack_valid));
        tick();
        ack_valid = '0;
        tick();
        chk(slot_cmd(2) == 6 && slot_dat(2) == 8'hC3, "R8 GntE node2", slot_dat(2), 8'hC3);
        consume_slot(2);
    endtask

    task automatic t_rotation();
        logic [N-1:0] win, lose;
        int w;
        set_req(0, MSG_REQ_SH);
        set_req(1, MSG_REQ_SH);
        #1;
        win = req_take;
        chk($countones(win) == 1 && (win & 4'b0011) == win, "R10 single winner", int'(win), 1);
        lose = 4'b0011 & ~win;
        w = win[1] ? 1 : 0;
        tick();
        set_req(w, MSG_NONE);
        tick();
        chk(slot_cmd(2) == 3, "R4 inv owner again", slot_cmd(2), 3);
        consume_slot(2);
        send_ack(2, 8'h3C, "R5 ack owner again");
        tick();
        chk(slot_cmd(w) == 5 && slot_dat(w) == 8'h3C, "R6 new data in GntS", slot_dat(w), 8'h3C);
        set_req(w, MSG_REQ_SH);
        gnt_take[w] = 1'b1;
        #1;
        chk(req_take == lose, "R10 waiting node wins", int'(req_take), int'(lose));
        tick();
        gnt_take = '0;
        req_cmd = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_shared();
        t_exclusive_over_sharer();
        t_ack_idle();
        t_shared_over_excl();
        t_shared_no_inv();
        t_priority();
        t_rotation();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule